// File: doc/BRIEF.md
# Overcurrent Setpoint Capture Counter

This block turns an analog protection setpoint into a stored digital code by the counting method. When a capture is started, a code counter begins at zero and climbs by one step for every prescaled tick. The code drives an external DAC. An external comparator reports when the DAC output rises above the voltage that a current source develops across the setpoint resistor. On the first clock where the comparator reports that the DAC is above the setpoint, the counter stops. The code it holds then serves as the overcurrent threshold.

Because the held value is a register and not a charge on a capacitor, it does not decay. It stays valid for as long as the power-valid flag is asserted. Dropping that flag clears the code and aborts any capture that is running, and a later start strobe takes a fresh sample. A larger setpoint means more steps, so a capture takes longer. A setpoint beyond the usable range, which includes an open resistor that never trips the comparator, marks protection as disabled. While a capture runs, the block holds the low-side gate drive off so that the setpoint pin can be measured.

Top module: `ocp_setpoint_capture`

## Requirements
- R1: While rst_n is low, thr_code is 0, and ocp_off, cap_done and lsg_off are all 0.
- R2: A cap_start pulse seen while idle with pwr_ok high starts a capture. On the next clock edge lsg_off goes to 1, thr_code goes to 0 and ocp_off goes to 0.
- R3: During a capture, thr_code rises by exactly 1 every PRESCALE clock cycles (default 4). Code k is present after 4k edges, counted from the edge that accepted cap_start.
- R4: The first cycle in which dac_above is 1 during a capture ends the capture on that edge, and thr_code keeps its current value. With the defaults, a capture that trips at code k raises cap_done after 4k+1 edges.
- R5: If dac_above is 1 in the same cycle as a step tick, the trip wins and thr_code is not incremented.
- R6: If a step tick arrives with thr_code at full scale (63) and no trip, the capture ends with thr_code = 63 and ocp_off = 1, after 4*64 edges.
- R7: A trip at a code above VALID_MAX (default 47) sets ocp_off to 1. A trip at a code of VALID_MAX or below leaves ocp_off at 0.
- R8: cap_done is high for exactly one cycle, and it rises on the same edge on which lsg_off falls.
- R9: While idle with pwr_ok high, thr_code and ocp_off hold their values, and dac_above has no effect. A cap_start during a capture has no effect on that capture.
- R10: pwr_ok low clears thr_code and ocp_off to 0 on the next edge. It also aborts a capture without raising cap_done, and while it stays low, cap_start is ignored.
- R11: lsg_off, which forces the low-side gate drive off, is 1 exactly while a capture is running.
- R12: A new capture started after a completed one replaces the held code and flag with the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Bias supply valid; low clears the held setpoint |
| cap_start | input | 1 | Strobe that begins a capture |
| dac_above | input | 1 | Comparator result: DAC output above setpoint voltage |
| thr_code | output | CODE_W | DAC code while capturing, held threshold afterwards |
| cap_done | output | 1 | One-cycle strobe at the end of a capture |
| ocp_off | output | 1 | Protection disabled, because the setpoint is out of range or open |
| lsg_off | output | 1 | Capture running; low-side gate drive held off |

## Verification
The comparator trip and the step tick can fall in the same cycle, and the trip must then win. To provoke this, the bench holds the comparator low until the code reaches 2. It then raises the comparator exactly in the last prescaler cycle of that step. It judges the result by requiring cap_done 12 edges after the start with thr_code still at 2, not 3. A second overlap, pwr_ok falling in the middle of a capture, is judged by the absence of cap_done and by a cleared code.

// File: rtl/ocp_cap_pkg.sv
package ocp_cap_pkg;
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/ocp_step_tick.sv
// Prescaler: one tick per PRESCALE cycles while run is high; restarts when run drops.
module ocp_step_tick #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ocp_code_ctr.sv
// Code register: cleared, incremented or held.
module ocp_code_ctr #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [CODE_W-1:0] code,
    output logic              at_full
);
    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (clr)      code_d = '0;
        else if (inc) code_d = code_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign code    = code_q;
    assign at_full = &code_q;
endmodule

// File: rtl/ocp_cap_ctrl.sv
// Capture sequencer: start, trip/tick arbitration, range judgement, power loss.
module ocp_cap_ctrl
    import ocp_cap_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int VALID_MAX = 47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              start,
    input  logic              trip,
    input  logic              tick,
    input  logic              at_full,
    input  logic [CODE_W-1:0] code,
    output logic              code_clr,
    output logic              code_inc,
    output logic              busy,
    output logic              done,
    output logic              off
);
    localparam logic [CODE_W-1:0] VMAX_C = CODE_W'(VALID_MAX);

    typedef struct packed {
        cap_state_e st;
        logic       done;
        logic       off;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        code_clr = 1'b0;
        code_inc = 1'b0;
        if (!pwr_ok) begin
            r_d.st   = CAP_IDLE;
            r_d.off  = 1'b0;
            code_clr = 1'b1;
        end else begin
            unique case (r_q.st)
                CAP_IDLE: begin
                    if (start) begin
                        r_d.st   = CAP_RUN;
                        r_d.off  = 1'b0;
                        code_clr = 1'b1;
                    end
                end
                CAP_RUN: begin
                    if (trip) begin
                        r_d.st   = CAP_IDLE;
                        r_d.done = 1'b1;
                        r_d.off  = (code > VMAX_C);
                    end else if (tick) begin
                        if (at_full) begin
                            r_d.st   = CAP_IDLE;
                            r_d.done = 1'b1;
                            r_d.off  = 1'b1;
                        end else begin
                            code_inc = 1'b1;
                        end
                    end
                end
                default: r_d.st = CAP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: CAP_IDLE, done: 1'b0, off: 1'b0};
        else        r_q <= r_d;
    end

    assign busy = (r_q.st == CAP_RUN);
    assign done = r_q.done;
    assign off  = r_q.off;
endmodule

// File: rtl/ocp_setpoint_capture.sv
module ocp_setpoint_capture #(
    parameter int CODE_W    = 6,
    parameter int VALID_MAX = 47,
    parameter int PRESCALE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              cap_start,
    input  logic              dac_above,
    output logic [CODE_W-1:0] thr_code,
    output logic              cap_done,
    output logic              ocp_off,
    output logic              lsg_off
);
    logic busy, tick, clr, inc, at_full;

    ocp_step_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    ocp_code_ctr #(.CODE_W(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc),
        .code(thr_code), .at_full(at_full)
    );

    ocp_cap_ctrl #(.CODE_W(CODE_W), .VALID_MAX(VALID_MAX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .start(cap_start),
        .trip(dac_above), .tick(tick), .at_full(at_full), .code(thr_code),
        .code_clr(clr), .code_inc(inc), .busy(busy), .done(cap_done),
        .off(ocp_off)
    );

    assign lsg_off = busy;
endmodule

// File: rtl/ocp_setpoint_capture_chk.sv
module ocp_setpoint_capture_chk #(
    parameter int CODE_W    = 6,
    parameter int VALID_MAX = 47
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic [CODE_W-1:0] thr_code,
    input logic              cap_done,
    input logic              ocp_off,
    input logic              lsg_off
);
    localparam logic [CODE_W-1:0] VMAX_C = CODE_W'(VALID_MAX);

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (lsg_off && $past(lsg_off)) |->
        (thr_code == $past(thr_code) || thr_code == $past(thr_code) + 1'b1));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !cap_done);

    a_r8_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> (!lsg_off && $past(lsg_off)));

    a_r7_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_done && !ocp_off) |-> (thr_code <= VMAX_C));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $past(pwr_ok) && !lsg_off && !$past(lsg_off)) |->
        ($stable(thr_code) && $stable(ocp_off)));

    a_r10_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (thr_code == '0 && !ocp_off && !lsg_off && !cap_done));
endmodule

bind ocp_setpoint_capture ocp_setpoint_capture_chk #(
    .CODE_W(CODE_W), .VALID_MAX(VALID_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .thr_code(thr_code),
    .cap_done(cap_done), .ocp_off(ocp_off), .lsg_off(lsg_off)
);

// File: tb/tb_ocp_setpoint_capture.sv
module tb_ocp_setpoint_capture;
    localparam int CODE_W = 6;

    typedef struct packed {
        int thr;
        int exp_code;
        int exp_off;
        int exp_cyc;
    } vec_t;

    // setpoint (bench DAC threshold), expected code, flag, edges to done
    localparam vec_t VECS [7] = '{
        '{-1,  0, 0,   1},
        '{ 0,  1, 0,   5},
        '{ 9, 10, 0,  41},
        '{46, 47, 0, 189},
        '{47, 48, 1, 193},
        '{62, 63, 1, 253},
        '{100, 63, 1, 256}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b1;
    logic cap_start = 1'b0;
    logic dac_above;
    logic [CODE_W-1:0] thr_code;
    logic cap_done, ocp_off, lsg_off;

    int  thr = 1000;
    bit  force_en = 1'b0;
    bit  force_val = 1'b0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc_total = 0;

    always #2 clk = ~clk;

    always_comb dac_above = force_en ? force_val : (int'(thr_code) > thr);

    ocp_setpoint_capture dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cap_start(cap_start),
        .dac_above(dac_above), .thr_code(thr_code), .cap_done(cap_done),
        .ocp_off(ocp_off), .lsg_off(lsg_off)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Pulse start, count edges until cap_done; checks R2/R11 on the first edge.
    task automatic run_cap(output int cyc, output bit got, input int lim);
        cap_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cap_start = 1'b0;
        check(lsg_off == 1'b1, "R11 lsg_off during capture", lsg_off, 1);
        check(thr_code == 0 && ocp_off == 0, "R2 start clears code", thr_code, 0);
        cyc = 0;
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (cap_done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        int cyc;
        bit got;
        int held;
        @(negedge clk);
        check(thr_code == 0 && !cap_done && !ocp_off && !lsg_off, "R1 reset state", thr_code, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 R4 R6 R7 R12
        foreach (VECS[k]) begin
            thr = VECS[k].thr;
            run_cap(cyc, got, 400);
            check(got, "R4 done seen", got, 1);
            check(cyc == VECS[k].exp_cyc, "R3 R4 R6 capture length", cyc, VECS[k].exp_cyc);
            check(int'(thr_code) == VECS[k].exp_code, "R4 R6 R12 held code", thr_code, VECS[k].exp_code);
            check(int'(ocp_off) == VECS[k].exp_off, "R7 disabled flag", ocp_off, VECS[k].exp_off);
            check(!lsg_off, "R11 lsg_off released", lsg_off, 0);
            @(negedge clk);
            check(!cap_done, "R8 done one cycle", cap_done, 0);
        end

        // R9: idle hold, comparator ignored
        thr = 20;
        run_cap(cyc, got, 400);
        held = thr_code;
        force_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            force_val = i[0];
            @(negedge clk);
        end
        force_en = 1'b0;
        check(int'(thr_code) == held && !lsg_off && !cap_done, "R9 idle hold", thr_code, held);

        // R9: start during capture ignored
        thr = 5;
        cap_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc = 0;
        got = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (cyc == 10) cap_start = 1'b0;
            if (cap_done) begin got = 1'b1; break; end
        end
        cap_start = 1'b0;
        check(got && cyc == 25 && thr_code == 6, "R9 start ignored in capture", cyc, 25);

        // R5: trip and tick coincide at code 2 (tick in cycle after edge 11)
        thr = 1000;
        force_en = 1'b1;
        force_val = 1'b0;
        cap_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cap_start = 1'b0;
        for (int i = 0; i < 11; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check(thr_code == 2 && !cap_done, "R5 setup code", thr_code, 2);
        force_val = 1'b1;
        @(posedge clk);
        @(negedge clk);
        force_en = 1'b0;
        check(cap_done && thr_code == 2, "R5 trip wins over tick", thr_code, 2);

        // R10: power loss mid-capture aborts without done
        thr = 30;
        cap_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cap_start = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        pwr_ok = 1'b0;
        got = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(thr_code == 0 && !ocp_off && !lsg_off && !cap_done, "R10 power loss clears", thr_code, 0);
        cap_start = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (cap_done || lsg_off) got = 1'b1;
        end
        cap_start = 1'b0;
        check(!got, "R10 start ignored without power", got, 0);

        // R10 then R12: power back, fresh capture
        pwr_ok = 1'b1;
        @(negedge clk);
        thr = 3;
        run_cap(cyc, got, 400);
        check(got && thr_code == 4 && cyc == 17, "R12 recapture after power", thr_code, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule